// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synchronous static memory whose bus can switch between reads and writes on every clock with no idle cycle. Address, control and byte-lane enables are captured on the rising clock edge. Write data is taken late, by exactly as many cycles as read data trails its read command. A read slot and a write slot therefore use the shared data bus in different cycles, even when read and write commands alternate on every edge.

A static mode pin selects one of two timings. In registered-output timing the read data passes through an output register and the lag is two cycles. In flow-through timing the array drives the bus directly and the lag is one cycle. A built-in two-bit burst counter lets a continue cycle step through the four words around a loaded address, in linear or interleaved order. The core also has a clock-enable stall, an asynchronous output enable and a sleep input. The bidirectional bus is split into `wdata`, `rdata` and `rdata_oe`.

Top module: `zt_sram`

## Requirements
- R1: With `flow_n` high (registered timing), the read data for a load cycle registered at edge k appears on `rdata` with `rdata_oe` high in the cycle that follows edge k+1.
- R2: With `flow_n` low (flow-through timing), the read data for a load cycle registered at edge k appears with `rdata_oe` high in the cycle that follows edge k.
- R3: Write data for a write registered at edge k is sampled from `wdata` at edge k+2 in registered timing and at edge k+1 in flow-through timing. Values present on `wdata` at any other edge are not stored.
- R4: Reads and writes may alternate on every edge with no idle cycle. A read always returns the data of every earlier write to the same address, including a write whose data has not yet been written into the array.
- R5: A load cycle (`burst_go` low) selects the device only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. Any other combination is a deselect: nothing is written and `rdata_oe` stays low for that slot.
- R6: `lane_wr_n[i]` is active low and gates byte lane i, which is bits `[9*i+8 : 9*i]` of the word. A write with every lane enable high leaves memory unchanged.
- R7: A continue cycle (`burst_go` high) ignores the chip selects and `wr_n`. It repeats the type of the burst in progress. Its address keeps the upper bits of the loaded address and replaces the two low bits with base+n (mod 4) when `burst_ilv` is 0, or base XOR n when it is 1, with n = 1, 2, 3, 0, ... After a deselect, a continue cycle stays deselected.
- R8: While `clk_en_n` is high, no register or memory word changes. A read already on the bus stays driven, and commands presented during the stall are lost.
- R9: `out_en_n` high turns `rdata_oe` off at once, without a clock and without changing the data. The read data comes back when `out_en_n` returns low. `rdata_oe` is also low in every write slot.
- R10: While `sleep` is high, `rdata_oe` is low and no command is accepted. A read captured before sleep completes after sleep ends.
- R11: While `rst_n` is low, and in the cycle after reset, `rdata_oe` is low and no slot is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_n | input | 1 | Timing mode: low = flow-through, high = registered; change only in reset |
| burst_ilv | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| sleep | input | 1 | Sleep: blocks operations and disables the drivers |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the core |
| burst_go | input | 1 | 0 = load a new address, 1 = continue the burst |
| wr_n | input | 1 | 0 = write, 1 = read on a load cycle |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| addr | input | AW | Word address |
| lane_wr_n | input | LANES | Byte-lane write enables, active low |
| wdata | input | DW | Late write data |
| rdata | output | DW | Read data |
| rdata_oe | output | 1 | High when the core drives the data bus |

## Verification
The properties assume that `flow_n` is held steady outside reset and that every input is a known value at each sampled edge. The stall property also assumes that the mode does not change during a stall. The stimulus changes the mode only while reset is asserted, drives all inputs to defined levels one time unit after each rising edge, and ends every command sequence with a deselect. This keeps the held input values from repeating a write while the bench waits. Write data is driven only in the cycle its requirement names, and zero otherwise, so any data capture at the wrong edge corrupts a word that is read back later.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flow_n,
  input  logic                            burst_ilv,
  input  logic                            sleep,
  input  logic                            out_en_n,
  input  logic                            clk_en_n,
  input  logic                            burst_go,
  input  logic                            wr_n,
  input  logic                            sel_a_n,
  input  logic                            sel_b,
  input  logic                            sel_c_n,
  input  logic [$clog2(DEPTH)-1:0]        addr,
  input  logic [LANES-1:0]                lane_wr_n,
  input  logic [LANES*LANE_W-1:0]         wdata,
  output logic [LANES*LANE_W-1:0]         rdata,
  output logic                            rdata_oe
);
  localparam int DW = LANES * LANE_W;
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {K_IDLE, K_RD, K_WR} kind_t;

  logic [DW-1:0] mem [DEPTH];

  logic          en;
  logic          picked;
  kind_t         burst_k, cmd_k;
  logic [AW-1:0] base, cmd_a;
  logic [1:0]    cnt, nxt, low;

  logic             s1_rd, s1_wr, s2_rd, s2_wr;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_m, s2_m;
  logic [DW-1:0]    q_reg, q_next;

  logic             wr_go;
  logic [AW-1:0]    wa;
  logic [LANES-1:0] wm;

  assign en     = !clk_en_n && !sleep;
  assign picked = !sel_a_n && sel_b && !sel_c_n;
  assign nxt    = cnt + 2'd1;
  assign low    = burst_ilv ? (base[1:0] ^ nxt) : (base[1:0] + nxt);
  assign cmd_k  = burst_go ? burst_k : (picked ? (wr_n ? K_RD : K_WR) : K_IDLE);
  assign cmd_a  = burst_go ? {base[AW-1:2], low} : addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      burst_k <= K_IDLE;
      base    <= '0;
      cnt     <= '0;
    end else if (en) begin
      if (!burst_go) begin
        burst_k <= cmd_k;
        base    <= addr;
        cnt     <= '0;
      end else begin
        cnt     <= nxt;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_rd <= 1'b0; s1_wr <= 1'b0; s1_a <= '0; s1_m <= '0;
      s2_rd <= 1'b0; s2_wr <= 1'b0; s2_a <= '0; s2_m <= '0;
    end else if (en) begin
      s1_rd <= (cmd_k == K_RD);
      s1_wr <= (cmd_k == K_WR);
      s1_a  <= cmd_a;
      s1_m  <= ~lane_wr_n;
      s2_rd <= s1_rd;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_m  <= s1_m;
    end

  assign wr_go = en && (flow_n ? s2_wr : s1_wr);
  assign wa    = flow_n ? s2_a : s1_a;
  assign wm    = flow_n ? s2_m : s1_m;

  always_ff @(posedge clk)
    if (wr_go)
      for (int i = 0; i < LANES; i++)
        if (wm[i]) mem[wa][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];

  always_comb
    for (int i = 0; i < LANES; i++)
      q_next[i*LANE_W +: LANE_W] = (s2_wr && s2_m[i] && s2_a == s1_a)
                                   ? wdata[i*LANE_W +: LANE_W]
                                   : mem[s1_a][i*LANE_W +: LANE_W];

  always_ff @(posedge clk)
    if (en) q_reg <= q_next;

  assign rdata    = flow_n ? q_reg : mem[s1_a];
  assign rdata_oe = !sleep && !out_en_n && (flow_n ? s2_rd : s1_rd);
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flow_n,
  input logic          sleep,
  input logic          out_en_n,
  input logic          clk_en_n,
  input logic          burst_go,
  input logic          wr_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe
);
  a_r11_reset_quiet: assert property (@(posedge clk) !rst_n |=> !rdata_oe)
    else $error("reset left the bus driven");

  a_r10_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_oe) else $error("bus driven in sleep");

  a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_oe) else $error("bus driven with output enable off");

  a_r9_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_n && !clk_en_n && !sleep && !burst_go && !sel_a_n && sel_b && !sel_c_n && !wr_n)
    |=> !rdata_oe) else $error("bus driven in a flow-through write slot");

  a_r5_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_n && !clk_en_n && !sleep && !burst_go && !(!sel_a_n && sel_b && !sel_c_n))
    |=> !rdata_oe) else $error("bus driven after a deselect");

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n || sleep) |=> $stable(rdata)) else $error("read data moved during a stall");
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flow_n(flow_n), .sleep(sleep), .out_en_n(out_en_n),
  .clk_en_n(clk_en_n), .burst_go(burst_go), .wr_n(wr_n), .sel_a_n(sel_a_n),
  .sel_b(sel_b), .sel_c_n(sel_c_n), .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int PERIOD = 10;
  localparam int LANES = 2, LANE_W = 9, DEPTH = 64;
  localparam int DW = LANES * LANE_W;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, flow_n = 1, burst_ilv = 0, sleep = 0, out_en_n = 0;
  logic clk_en_n = 0, burst_go = 0, wr_n = 1, sel_a_n = 1, sel_b = 0, sel_c_n = 1;
  logic [AW-1:0]    addr = '0;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [DW-1:0]    wdata = '0;
  wire  [DW-1:0]    rdata;
  wire              rdata_oe;

  zt_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .flow_n(flow_n), .burst_ilv(burst_ilv), .sleep(sleep),
    .out_en_n(out_en_n), .clk_en_n(clk_en_n), .burst_go(burst_go), .wr_n(wr_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .addr(addr),
    .lane_wr_n(lane_wr_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, cur = 0, lag = 2;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] wdq [int];
  int            due_q[$];
  bit            oe_q[$];
  logic [DW-1:0] d_q[$];
  string         tag_q[$];
  int            bkind = 0;
  logic [AW-1:0] bbase = '0;
  logic [1:0]    bcnt = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int due, input bit oe, input logic [DW-1:0] d, input string tag);
    due_q.push_back(due); oe_q.push_back(oe); d_q.push_back(d); tag_q.push_back(tag);
  endtask

  always @(negedge clk)
    for (int i = due_q.size() - 1; i >= 0; i--)
      if (due_q[i] == cyc) begin
        checks++;
        if (oe_q[i] ? !(rdata_oe === 1'b1 && rdata === d_q[i]) : (rdata_oe !== 1'b0)) begin
          fails++;
          $display("FAIL %s cyc=%0d actual oe=%b data=%h expected oe=%b data=%h",
                   tag_q[i], cyc, rdata_oe, rdata, oe_q[i], d_q[i]);
        end
        due_q.delete(i); oe_q.delete(i); d_q.delete(i); tag_q.delete(i);
      end

  task automatic drive(input bit stall, input bit go, input bit wrn, input int bad,
                       input logic [AW-1:0] a, input logic [LANES-1:0] ln);
    @(posedge clk); #1;
    cur = cyc;
    clk_en_n = stall; burst_go = go; wr_n = wrn; addr = a; lane_wr_n = ln;
    sel_a_n = (bad == 1); sel_b = (bad != 2); sel_c_n = (bad == 3);
    wdata = wdq.exists(cur) ? wdq[cur] : '0;
  endtask

  task automatic apply(input logic [AW-1:0] a, input logic [LANES-1:0] ln, input logic [DW-1:0] d);
    for (int i = 0; i < LANES; i++)
      if (!ln[i]) model[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag, input bit p = 1);
    drive(0, 0, 1, 0, a, '1);
    bkind = 1; bbase = a; bcnt = 0;
    if (p) push(cur + lag, 1, model[a], tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] ln, input logic [DW-1:0] d,
                    input string tag);
    drive(0, 0, 0, 0, a, ln);
    bkind = 2; bbase = a; bcnt = 0;
    wdq[cur + lag] = d;
    apply(a, ln, d);
    push(cur + lag, 0, '0, tag);
  endtask

  task automatic desel(input int bad = 1, input bit wrn = 1, input logic [AW-1:0] a = '0,
                       input logic [DW-1:0] d = '0, input string tag = "R5");
    drive(0, 0, wrn, bad, a, '0);
    bkind = 0;
    if (!wrn) wdq[cur + lag] = d;
    push(cur + lag, 0, '0, tag);
  endtask

  task automatic cont(input logic [LANES-1:0] ln, input logic [DW-1:0] d, input string tag);
    logic [AW-1:0] a;
    drive(0, 1, 0, 1, '1, ln);
    bcnt = bcnt + 2'd1;
    a = {bbase[AW-1:2], burst_ilv ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt)};
    if (bkind == 1) push(cur + lag, 1, model[a], tag);
    else begin
      wdq[cur + lag] = d;
      if (bkind == 2) apply(a, ln, d);
      push(cur + lag, 0, '0, tag);
    end
  endtask

  task automatic set_mode(input bit f);
    repeat (4) @(posedge clk);
    #1;
    burst_go = 0; sel_a_n = 1; wr_n = 1; clk_en_n = 0;
    rst_n = 0; flow_n = f; lag = f ? 2 : 1;
    @(negedge clk);
    chk("R11 oe in reset", {17'd0, rdata_oe}, '0);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk("R11 oe after reset", {17'd0, rdata_oe}, '0);
  endtask

  task automatic stall_test();
    rd(1, "R8 before stall");
    if (flow_n) rd(2, "", 0);
    drive(1, 0, 0, 0, 1, '0);
    push(cur + 1, 1, model[1], "R8 held during stall");
    desel();
    if (flow_n) push(cur + 1, 1, model[2], "R8 resumed after stall");
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    set_mode(1);

    for (int a = 0; a < 16; a++) wr(AW'(a), '0, DW'(a * 18'h0421 + 18'h10003), "R3");
    desel();
    for (int a = 0; a < 16; a += 5) rd(AW'(a), "R1");
    desel(); desel();
    rd(2, "R1 exact lag after deselect");
    desel(); desel();

    wr(20, '0, 18'h2AAAA, "R4"); rd(20, "R4 forward pending write");
    wr(21, '0, 18'h15555, "R4"); rd(20, "R4"); rd(21, "R4 forward");
    wr(20, '0, 18'h3C3C3, "R4"); rd(21, "R4"); rd(20, "R4 after second write");
    desel(); desel();

    wr(3, 2'b10, 18'h3FFFF, "R6 lane0 only");
    wr(3, 2'b01, 18'h12345, "R6 lane1 only");
    wr(3, 2'b11, 18'h00000, "R6 abort");
    rd(3, "R6 masked result");
    desel();

    desel(1, 0, 4, 18'h3FFFF, "R5 sel_a_n high");
    desel(2, 0, 4, 18'h3FFFF, "R5 sel_b low");
    desel(3, 0, 4, 18'h3FFFF, "R5 sel_c_n high");
    rd(4, "R5 deselected write lost");
    desel();

    burst_ilv = 0;
    wr(13, '0, 18'h01111, "R7");
    cont('0, 18'h02222, "R7 linear write");
    cont('0, 18'h03333, "R7 linear write");
    cont('0, 18'h04444, "R7 linear write wrap");
    desel();
    rd(13, "R7");
    for (int n = 0; n < 4; n++) cont('1, '0, "R7 linear read order and wrap");
    desel();
    rd(14, "R7 linear target"); rd(12, "R7 linear wrap target");
    desel();
    burst_ilv = 1;
    rd(13, "R7");
    for (int n = 0; n < 3; n++) cont('1, '0, "R7 interleaved read order");
    desel();
    wr(33, '0, 18'h0ABCD, "R7");
    cont('0, 18'h0BCDE, "R7 interleaved write");
    cont('0, 18'h0CDEF, "R7 interleaved write");
    desel();
    rd(32, "R7 interleaved target"); rd(35, "R7 interleaved target");
    desel();
    cont('0, 18'h3FFFF, "R7 continue after deselect");
    cont('0, 18'h3FFFF, "R7 continue after deselect");
    rd(13, "R7 unchanged after deselect continue"); rd(14, "R7"); rd(12, "R7");
    desel();
    burst_ilv = 0;

    desel(); desel();
    stall_test();
    rd(1, "R8 stalled write lost");
    desel(); desel();

    rd(6, "R9");
    desel();
    @(negedge clk); @(negedge clk); #1;
    out_en_n = 1; #1;
    chk("R9 async off", {17'd0, rdata_oe}, '0);
    chk("R9 data kept", rdata, model[6]);
    out_en_n = 0; #1;
    chk("R9 async back on", {17'd0, rdata_oe}, 18'd1);

    desel(); desel();
    rd(7, "", 0);
    @(posedge clk); #1;
    sleep = 1; burst_go = 0; wr_n = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    addr = 8; lane_wr_n = '0; wdata = '1;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk("R10 oe in sleep", {17'd0, rdata_oe}, '0);
      @(posedge clk); #1;
    end
    sleep = 0; sel_a_n = 1; wr_n = 1; wdata = '0;
    push(cyc + 1, 1, model[7], "R10 read resumes after sleep");
    desel();
    rd(8, "R10 write in sleep lost");
    desel();

    set_mode(0);
    desel();
    rd(5, "R2 flow read");
    desel();
    rd(0, "R2 exact lag after deselect");
    wr(40, '0, 18'h1E1E1, "R3 flow write");
    rd(40, "R3 R4 flow read after write");
    wr(41, '0, 18'h01F0F, "R4 flow");
    rd(41, "R4 flow alternate"); wr(40, 2'b01, 18'h2FFFF, "R6 flow lane1");
    rd(40, "R6 flow merged");
    desel();
    stall_test();
    rd(1, "R8 flow stalled write lost");
    desel();

    repeat (5) @(posedge clk);
    chk("R1 scoreboard drained", DW'(due_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule